// File: doc/BRIEF.md
# Double-Buffered SPI Controller

This block moves 8-bit frames over a four-wire-style serial link, most significant bit first, either as the clock master or as a slave that follows an external clock. Each direction has a one-byte holding buffer next to its own shift register. Software can therefore queue the next transmit byte while the current one is still shifting, and a received byte can wait in the buffer while the next one arrives.

Three sticky flags report the data path: transmit-buffer-empty, receive-buffer-full and overrun. Each is cleared by a one on its bit of the clear vector. The first two also serve directly as interrupt or DMA request lines. In master mode the serial clock comes from a programmable divider and follows all four polarity/phase settings. In slave mode the external clock is synchronised and its edges are detected in the core clock domain. A receive byte that completes while the buffer is still full is held in the shift register. Overrun is flagged when the next frame's first bit is sampled.

Top module: `spi_dbuf_ctrl`

## Requirements
- R1: After reset all three flags, `busy` and `rx_data` are 0, and `ser_clk_o` equals `cfg_cpol`.
- R2: In master mode a write to `tx_data` starts one frame of exactly 16 serial clock edges. With `ser_di` looped back to `ser_do`, the transmitted byte lands in `rx_data`. Between frames `ser_clk_o` rests at `cfg_cpol`.
- R3: Bits are MSB first. An edge is leading when it leaves the `cfg_cpol` level. With `cfg_cpha`=0 the input is sampled on leading edges and `ser_do` changes on trailing edges. With `cfg_cpha`=1 it is the other way round, and the first leading edge presents bit 7 without shifting.
- R4: In master mode every serial clock half-period inside a frame lasts `cfg_div`+1 core clock cycles.
- R5: `txe_req` (flag_clr bit 0) sets when the buffered byte moves into the shift register. It stays set until cleared. A set arriving in the same cycle as a clear wins.
- R6: Writing `tx_data` while an earlier byte still waits in the buffer replaces that byte, so the earlier byte is never sent.
- R7: In master mode `busy` is 1 from the cycle after a write until both the buffer and the shift register are empty. In slave mode `busy` is always 0.
- R8: In slave mode a byte written before the first external edge is shifted out on `ser_do`. The byte shifted in on `ser_di` reaches `rx_data` with `rxf_req` set.
- R9: `rxf_req` (flag_clr bit 1) sets when a completed byte is written to `rx_data`. It stays set until cleared. A set arriving in the same cycle as a clear wins.
- R10: While `rxf_req` is set, `rx_data` does not change, and a newly completed byte is kept in the shift register. Once `rxf_req` is cleared, that byte moves into `rx_data` and `rxf_req` sets again.
- R11: If a byte is being held and the first bit of the following frame is sampled while `rxf_req` is still set, `ovr_flag` (flag_clr bit 2) sets in that same cycle and the held byte is discarded. `ovr_flag` stays set until cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_master | input | 1 | 1 = master, 0 = slave |
| cfg_cpol | input | 1 | Idle level of the serial clock |
| cfg_cpha | input | 1 | 0 = sample on leading edge, 1 = sample on trailing edge |
| cfg_div | input | DIV_W | Master half-period length minus one, in core cycles |
| tx_wr | input | 1 | Write strobe for the transmit buffer |
| tx_data | input | 8 | Byte to transmit |
| flag_clr | input | 3 | Write-one-to-clear: bit 0 txe, bit 1 rxf, bit 2 overrun |
| rx_data | output | 8 | Receive buffer contents |
| txe_req | output | 1 | Transmit buffer emptied flag / request |
| rxf_req | output | 1 | Receive buffer full flag / request |
| ovr_flag | output | 1 | Receive overrun flag |
| busy | output | 1 | Master transfer in progress or pending |
| ser_clk_o | output | 1 | Serial clock driven in master mode |
| ser_clk_i | input | 1 | Serial clock received in slave mode |
| ser_do | output | 1 | Serial data out |
| ser_di | input | 1 | Serial data in |

## Verification
Two functions can hit a flag in the same cycle: the hardware setting it (a byte moving into the shift register, or a frame completing into the receive buffer) and a software clear. The bench holds the clear bits for `txe_req` and `rxf_req` high across a whole loop-back frame and counts the cycles in which each flag reads 1. A controller where set wins shows exactly one such cycle; one where clear wins shows none. A second collision is the first sample of a new frame landing while a byte is held. The bench notes the cycle of the seventeenth sampling edge it sees on the wire and checks that the overrun flag rises in that same cycle.

// File: rtl/spi_dbuf_pkg.sv
package spi_dbuf_pkg;

    localparam int unsigned BYTE_W      = 8;
    localparam int unsigned EDGES_FRAME = 2 * BYTE_W;
    localparam int unsigned ECNT_W      = $clog2(EDGES_FRAME);
    localparam int unsigned BCNT_W      = $clog2(BYTE_W);

    localparam int unsigned FLG_TXE = 0;
    localparam int unsigned FLG_RXF = 1;
    localparam int unsigned FLG_OVR = 2;
    localparam int unsigned FLG_N   = 3;

    typedef logic [BYTE_W-1:0] byte_t;

    // one serial clock edge as seen by the data path
    typedef struct packed {
        logic fire;   // an edge happens this cycle
        logic lead;   // edge leaves the idle level
        logic first;  // first edge of a frame
    } sclk_ev_t;

    // even edge numbers within a frame are leading edges
    function automatic logic edge_is_lead(input logic [ECNT_W-1:0] ecnt);
        return ~ecnt[0];
    endfunction

    // phase 0 samples on leading edges, phase 1 on trailing edges
    function automatic logic edge_is_sample(input logic lead, input logic cpha);
        return lead ^ cpha;
    endfunction

endpackage

// File: rtl/spi_dbuf_sclk.sv
module spi_dbuf_sclk
    import spi_dbuf_pkg::*;
#(
    parameter int unsigned DIV_W       = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             master,
    input  logic             cpol,
    input  logic [DIV_W-1:0] div,
    input  logic             start,
    input  logic             ser_clk_i,
    output sclk_ev_t         ev,
    output logic             ser_clk_o,
    output logic             mid_frame
);

    localparam logic [DIV_W-1:0]  TMR_ONE  = 1;
    localparam logic [ECNT_W-1:0] ECNT_ONE = 1;
    localparam logic [ECNT_W-1:0] ECNT_END = ECNT_W'(EDGES_FRAME - 1);

    logic [DIV_W-1:0]       tmr_q;
    logic [ECNT_W-1:0]      ecnt_q;
    logic                   run_q;
    logic                   phase_q;
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   sync_prev_q;
    logic                   m_fire;
    logic                   s_fire;

    // slave clock synchroniser, parked at the idle level during reset
    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q      <= {SYNC_STAGES{cpol}};
            sync_prev_q <= cpol;
        end else begin
            sync_q      <= {sync_q[SYNC_STAGES-2:0], ser_clk_i};
            sync_prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign m_fire = master & run_q & (tmr_q == div);
    assign s_fire = ~master & (sync_q[SYNC_STAGES-1] ^ sync_prev_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            tmr_q   <= '0;
            ecnt_q  <= '0;
            run_q   <= 1'b0;
            phase_q <= 1'b0;
        end else if (master) begin
            if (start && !run_q) begin
                run_q   <= 1'b1;
                tmr_q   <= '0;
                ecnt_q  <= '0;
                phase_q <= 1'b0;
            end else if (run_q) begin
                if (m_fire) begin
                    tmr_q   <= '0;
                    phase_q <= ~phase_q;
                    ecnt_q  <= ecnt_q + ECNT_ONE;
                    if (ecnt_q == ECNT_END) begin
                        run_q <= 1'b0;
                    end
                end else begin
                    tmr_q <= tmr_q + TMR_ONE;
                end
            end
        end else begin
            run_q <= 1'b0;
            if (s_fire) begin
                ecnt_q <= ecnt_q + ECNT_ONE;
            end
        end
    end

    assign ev.fire   = m_fire | s_fire;
    assign ev.lead   = edge_is_lead(ecnt_q);
    assign ev.first  = (ecnt_q == '0);
    assign ser_clk_o = phase_q ^ cpol;
    assign mid_frame = master ? run_q : (ecnt_q != '0);

endmodule

// File: rtl/spi_dbuf_tx.sv
module spi_dbuf_tx
    import spi_dbuf_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr,
    input  byte_t wdata,
    input  logic  clr,
    input  logic  mid_frame,
    input  logic  shift_en,
    output logic  load,
    output logic  full,
    output logic  txe,
    output logic  sdo
);

    byte_t hold_q;
    byte_t sh_q;
    logic  full_q;
    logic  txe_q;

    // the buffer is handed over only between frames
    assign load = full_q & ~mid_frame;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
            sh_q   <= '0;
            full_q <= 1'b0;
            txe_q  <= 1'b0;
        end else begin
            if (wr) begin
                hold_q <= wdata;
            end
            full_q <= wr | (full_q & ~load);
            if (load) begin
                sh_q <= hold_q;
            end else if (shift_en) begin
                sh_q <= {sh_q[BYTE_W-2:0], 1'b0};
            end
            txe_q <= load | (txe_q & ~clr);
        end
    end

    assign full = full_q;
    assign txe  = txe_q;
    assign sdo  = sh_q[BYTE_W-1];

endmodule

// File: rtl/spi_dbuf_rx.sv
module spi_dbuf_rx
    import spi_dbuf_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  smp_en,
    input  logic  sdi,
    input  logic  clr_rxf,
    input  logic  clr_ovr,
    output byte_t data,
    output logic  rxf,
    output logic  ovr
);

    localparam logic [BCNT_W-1:0] BCNT_ONE = 1;
    localparam logic [BCNT_W-1:0] BCNT_END = BCNT_W'(BYTE_W - 1);

    byte_t             sh_q;
    byte_t             buf_q;
    logic [BCNT_W-1:0] bcnt_q;
    logic              held_q;
    logic              rxf_q;
    logic              ovr_q;

    byte_t sh_nxt;
    logic  done;
    logic  lose;
    logic  take_new;
    logic  take_held;

    assign sh_nxt    = {sh_q[BYTE_W-2:0], sdi};
    assign done      = smp_en & (bcnt_q == BCNT_END);
    assign lose      = smp_en & (bcnt_q == '0) & held_q & rxf_q;
    assign take_new  = done & ~rxf_q;
    assign take_held = held_q & ~rxf_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q   <= '0;
            buf_q  <= '0;
            bcnt_q <= '0;
            held_q <= 1'b0;
            rxf_q  <= 1'b0;
            ovr_q  <= 1'b0;
        end else begin
            if (smp_en) begin
                sh_q   <= sh_nxt;
                bcnt_q <= bcnt_q + BCNT_ONE;
            end
            if (take_new) begin
                buf_q <= sh_nxt;
            end else if (take_held) begin
                buf_q <= sh_q;
            end
            if (done && rxf_q) begin
                held_q <= 1'b1;
            end else if (take_held || lose) begin
                held_q <= 1'b0;
            end
            rxf_q <= take_new | take_held | (rxf_q & ~clr_rxf);
            ovr_q <= lose | (ovr_q & ~clr_ovr);
        end
    end

    assign data = buf_q;
    assign rxf  = rxf_q;
    assign ovr  = ovr_q;

endmodule

// File: rtl/spi_dbuf_ctrl.sv
module spi_dbuf_ctrl
    import spi_dbuf_pkg::*;
#(
    parameter int unsigned DIV_W       = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_master,
    input  logic             cfg_cpol,
    input  logic             cfg_cpha,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic             tx_wr,
    input  logic [7:0]       tx_data,
    input  logic [2:0]       flag_clr,
    output logic [7:0]       rx_data,
    output logic             txe_req,
    output logic             rxf_req,
    output logic             ovr_flag,
    output logic             busy,
    output logic             ser_clk_o,
    input  logic             ser_clk_i,
    output logic             ser_do,
    input  logic             ser_di
);

    sclk_ev_t ev;
    logic     mid_frame;
    logic     load;
    logic     tx_full;
    logic     smp_en;
    logic     shift_en;

    spi_dbuf_sclk #(
        .DIV_W       (DIV_W),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_sclk (
        .clk       (clk),
        .rst       (rst),
        .master    (cfg_master),
        .cpol      (cfg_cpol),
        .div       (cfg_div),
        .start     (load),
        .ser_clk_i (ser_clk_i),
        .ev        (ev),
        .ser_clk_o (ser_clk_o),
        .mid_frame (mid_frame)
    );

    // sampling edges feed the receiver, the others advance the transmitter;
    // the opening edge of a frame never shifts (it presents bit 7)
    assign smp_en   = ev.fire & edge_is_sample(ev.lead, cfg_cpha);
    assign shift_en = ev.fire & ~edge_is_sample(ev.lead, cfg_cpha) & ~ev.first;

    spi_dbuf_tx u_tx (
        .clk       (clk),
        .rst       (rst),
        .wr        (tx_wr),
        .wdata     (tx_data),
        .clr       (flag_clr[FLG_TXE]),
        .mid_frame (mid_frame),
        .shift_en  (shift_en),
        .load      (load),
        .full      (tx_full),
        .txe       (txe_req),
        .sdo       (ser_do)
    );

    spi_dbuf_rx u_rx (
        .clk     (clk),
        .rst     (rst),
        .smp_en  (smp_en),
        .sdi     (ser_di),
        .clr_rxf (flag_clr[FLG_RXF]),
        .clr_ovr (flag_clr[FLG_OVR]),
        .data    (rx_data),
        .rxf     (rxf_req),
        .ovr     (ovr_flag)
    );

    assign busy = cfg_master & (tx_full | mid_frame);

endmodule

// File: rtl/spi_dbuf_ctrl_chk.sv
module spi_dbuf_ctrl_chk #(
    parameter int unsigned DIV_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             cfg_master,
    input logic             cfg_cpol,
    input logic [DIV_W-1:0] cfg_div,
    input logic             tx_wr,
    input logic [2:0]       flag_clr,
    input logic [7:0]       rx_data,
    input logic             txe_req,
    input logic             rxf_req,
    input logic             ovr_flag,
    input logic             busy,
    input logic             ser_clk_o
);

    // R2: clock rests at its idle level whenever the master is not busy
    a_r2_idle_level: assert property (@(posedge clk) disable iff (rst)
        (cfg_master && !busy) |-> (ser_clk_o == cfg_cpol));

    // R5: transmit-empty flag is sticky until cleared
    a_r5_txe_sticky: assert property (@(posedge clk) disable iff (rst)
        (txe_req && !flag_clr[0]) |=> txe_req);

    // R7: a master write makes the block busy on the next cycle
    a_r7_busy_on_write: assert property (@(posedge clk) disable iff (rst)
        (cfg_master && tx_wr) |=> busy);

    // R9: receive-full flag is sticky until cleared
    a_r9_rxf_sticky: assert property (@(posedge clk) disable iff (rst)
        (rxf_req && !flag_clr[1]) |=> rxf_req);

    // R10: buffer contents frozen while the full flag stands
    a_r10_data_frozen: assert property (@(posedge clk) disable iff (rst)
        (rxf_req && !flag_clr[1]) |=> $stable(rx_data));

    // R11: overrun is sticky and only rises while the buffer was full
    a_r11_ovr_sticky: assert property (@(posedge clk) disable iff (rst)
        (ovr_flag && !flag_clr[2]) |=> ovr_flag);

    a_r11_ovr_needs_full: assert property (@(posedge clk) disable iff (rst)
        $rose(ovr_flag) |-> $past(rxf_req));

    wire unused_ok = &{1'b0, cfg_div};

endmodule

bind spi_dbuf_ctrl spi_dbuf_ctrl_chk #(.DIV_W(DIV_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cfg_master (cfg_master),
    .cfg_cpol   (cfg_cpol),
    .cfg_div    (cfg_div),
    .tx_wr      (tx_wr),
    .flag_clr   (flag_clr),
    .rx_data    (rx_data),
    .txe_req    (txe_req),
    .rxf_req    (rxf_req),
    .ovr_flag   (ovr_flag),
    .busy       (busy),
    .ser_clk_o  (ser_clk_o)
);

// File: tb/test_spi_dbuf_ctrl.sv
`timescale 1ns/1ps
module test_spi_dbuf_ctrl;

    localparam int DIV_W = 4;
    localparam int H     = 6;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cfg_master = 1'b1;
    logic             cfg_cpol = 1'b0;
    logic             cfg_cpha = 1'b0;
    logic [DIV_W-1:0] cfg_div = '0;
    logic             tx_wr = 1'b0;
    logic [7:0]       tx_data = '0;
    logic [2:0]       flag_clr = '0;
    logic [7:0]       rx_data;
    logic             txe_req, rxf_req, ovr_flag, busy;
    logic             ser_clk_o, ser_do, ser_di;
    logic             ser_clk_i = 1'b0;
    logic             slv_di = 1'b0;

    always #2.5 clk = ~clk;

    assign ser_di = cfg_master ? ser_do : slv_di;

    spi_dbuf_ctrl #(.DIV_W(DIV_W)) i_spi_dbuf_ctrl (
        .clk(clk), .rst(rst), .cfg_master(cfg_master), .cfg_cpol(cfg_cpol),
        .cfg_cpha(cfg_cpha), .cfg_div(cfg_div), .tx_wr(tx_wr), .tx_data(tx_data),
        .flag_clr(flag_clr), .rx_data(rx_data), .txe_req(txe_req),
        .rxf_req(rxf_req), .ovr_flag(ovr_flag), .busy(busy),
        .ser_clk_o(ser_clk_o), .ser_clk_i(ser_clk_i), .ser_do(ser_do),
        .ser_di(ser_di)
    );

    int     n_chk = 0;
    int     n_bad = 0;
    longint cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // wire monitor, evaluated at the falling edge
    logic       mon_prev = 1'b0;
    logic       mon_lead;
    logic [7:0] mon_byte;
    logic [7:0] mon_q [8];
    int         mon_n, mon_bits, mon_edges, mon_gap, mon_gap_bad, mon_samples;
    int         rxf_hi, txe_hi;
    longint     smp17_cyc, ovr_cyc;
    logic       ovr_prev = 1'b0;

    always @(negedge clk) begin
        if (cfg_master && !rst) begin
            mon_gap++;
            if (ser_clk_o != mon_prev) begin
                mon_lead = (ser_clk_o != cfg_cpol);
                if ((mon_edges % 16) != 0 && mon_gap != int'(cfg_div) + 1) mon_gap_bad++;
                if (mon_lead ^ cfg_cpha) begin
                    mon_byte = {mon_byte[6:0], ser_do};
                    mon_bits++;
                    mon_samples++;
                    if (mon_samples == 17) smp17_cyc = cyc;
                    if (mon_bits == 8) begin
                        mon_q[mon_n % 8] = mon_byte;
                        mon_n++;
                        mon_bits = 0;
                    end
                end
                mon_edges++;
                mon_gap = 0;
            end
        end
        mon_prev = ser_clk_o;
        if (rxf_req) rxf_hi++;
        if (txe_req) txe_hi++;
        if (ovr_flag && !ovr_prev) ovr_cyc = cyc;
        ovr_prev = ovr_flag;
    end

    task automatic mon_clear();
        mon_n = 0; mon_bits = 0; mon_edges = 0; mon_gap = 0; mon_gap_bad = 0;
        mon_samples = 0; rxf_hi = 0; txe_hi = 0; smp17_cyc = -1; ovr_cyc = -2;
        mon_byte = '0;
    endtask

    task automatic cyc1();
        @(posedge clk);
        #1;
    endtask

    task automatic waitn(input int n);
        repeat (n) cyc1();
    endtask

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; tx_wr = 1'b0; flag_clr = '0;
        waitn(3);
        rst = 1'b0;
        cyc1();
    endtask

    task automatic write_tx(input logic [7:0] d);
        tx_data = d; tx_wr = 1'b1;
        cyc1();
        tx_wr = 1'b0;
    endtask

    task automatic clr(input logic [2:0] m);
        flag_clr = m;
        cyc1();
        flag_clr = '0;
    endtask

    task automatic wait_idle();
        int t = 0;
        while (busy && t < 3000) begin cyc1(); t++; end
        waitn(2);
    endtask

    task automatic wait_txe();
        int t = 0;
        while (!txe_req && t < 3000) begin cyc1(); t++; end
    endtask

    task automatic slave_byte(input logic [7:0] r, output logic [7:0] got);
        got = '0;
        for (int k = 7; k >= 0; k--) begin
            if (!cfg_cpha) begin
                slv_di = r[k];
                waitn(H);
                got = {got[6:0], ser_do};
                ser_clk_i = ~ser_clk_i;
                waitn(H);
                ser_clk_i = ~ser_clk_i;
            end else begin
                ser_clk_i = ~ser_clk_i;
                slv_di = r[k];
                waitn(H);
                got = {got[6:0], ser_do};
                ser_clk_i = ~ser_clk_i;
                waitn(H);
            end
        end
        waitn(H);
    endtask

    bit finished = 0;

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        mon_clear();
        // master sweep: all four modes, three dividers, eight bytes each
        for (int m = 0; m < 4; m++) begin
            for (int dv = 0; dv < 3; dv++) begin
                cfg_master = 1'b1; cfg_cpol = m[1]; cfg_cpha = m[0];
                cfg_div = DIV_W'(dv);
                do_reset();
                check(!txe_req && !rxf_req && !ovr_flag && !busy, "R1 flags after reset",
                      {txe_req, rxf_req, ovr_flag, busy}, 0);
                check(rx_data == 8'h00 && ser_clk_o == cfg_cpol, "R1 data/clock after reset",
                      {rx_data, ser_clk_o}, {8'h00, cfg_cpol});
                for (int i = 0; i < 8; i++) begin
                    logic [7:0] b;
                    b = 8'((i * 73 + m * 29 + dv * 11 + 5) ^ (i << 5));
                    mon_clear();
                    write_tx(b);
                    check(busy, "R7 busy after write", busy, 1);
                    wait_idle();
                    check(mon_n == 1 && mon_q[0] == b, "R3 bit order on wire", mon_q[0], b);
                    check(mon_edges == 16, "R2 edges per frame", mon_edges, 16);
                    check(mon_gap_bad == 0, "R4 half period", mon_gap_bad, 0);
                    check(rx_data == b && rxf_req, "R2 loopback byte", rx_data, b);
                    check(ser_clk_o == cfg_cpol && !busy, "R2 idle level", ser_clk_o, cfg_cpol);
                    check(txe_req, "R5 txe set on load", txe_req, 1);
                    clr(3'b011);
                    check(!rxf_req && !txe_req, "R9 flags cleared", {rxf_req, txe_req}, 0);
                end
            end
        end

        // set and clear in the same cycle: set must win
        cfg_cpol = 1'b0; cfg_cpha = 1'b0; cfg_div = DIV_W'(1);
        do_reset();
        mon_clear();
        flag_clr = 3'b011;
        write_tx(8'hA5);
        wait_idle();
        flag_clr = '0;
        check(txe_hi == 1, "R5 set beats clear", txe_hi, 1);
        check(rxf_hi == 1, "R9 set beats clear", rxf_hi, 1);
        check(rx_data == 8'hA5, "R9 data with collided clear", rx_data, 8'hA5);

        // overwrite of a waiting transmit byte, and holding of a received byte
        do_reset();
        mon_clear();
        write_tx(8'h3C);
        check(busy, "R7 busy after write", busy, 1);
        wait_txe();
        clr(3'b001);
        write_tx(8'hC3);
        write_tx(8'h5A);
        wait_idle();
        check(mon_n == 2, "R6 frames sent", mon_n, 2);
        check(mon_q[0] == 8'h3C, "R6 first frame", mon_q[0], 8'h3C);
        check(mon_q[1] == 8'h5A, "R6 overwritten byte replaced", mon_q[1], 8'h5A);
        check(rx_data == 8'h3C && rxf_req, "R10 buffer kept while full", rx_data, 8'h3C);
        check(!busy, "R7 busy low when idle", busy, 0);
        check(!ovr_flag, "R11 no overrun on two bytes", ovr_flag, 0);
        clr(3'b010);
        waitn(2);
        check(rx_data == 8'h5A && rxf_req, "R10 held byte moves after clear", rx_data, 8'h5A);

        // overrun on the first bit of the third frame
        do_reset();
        mon_clear();
        write_tx(8'h11);
        wait_txe();
        clr(3'b001);
        write_tx(8'h22);
        wait_txe();
        clr(3'b001);
        write_tx(8'h33);
        wait_idle();
        check(ovr_flag, "R11 overrun raised", ovr_flag, 1);
        check(ovr_cyc == smp17_cyc, "R11 overrun on first bit of third frame", ovr_cyc, smp17_cyc);
        check(rx_data == 8'h11, "R11 first byte kept", rx_data, 8'h11);
        clr(3'b110);
        waitn(2);
        check(!ovr_flag, "R11 overrun cleared", ovr_flag, 0);
        check(rx_data == 8'h33 && rxf_req, "R11 second byte lost", rx_data, 8'h33);

        // slave sweep
        for (int m = 0; m < 4; m++) begin
            cfg_master = 1'b0; cfg_cpol = m[1]; cfg_cpha = m[0];
            ser_clk_i = m[1];
            do_reset();
            for (int i = 0; i < 4; i++) begin
                logic [7:0] t;
                logic [7:0] r;
                logic [7:0] got;
                t = 8'((i * 91 + m * 37 + 3) ^ 8'h96);
                r = 8'((i * 53 + m * 17 + 9) ^ 8'h4B);
                write_tx(t);
                waitn(2);
                check(txe_req, "R8 slave byte loaded before clock", txe_req, 1);
                check(!busy, "R7 busy stays low in slave mode", busy, 0);
                clr(3'b001);
                slave_byte(r, got);
                check(got == t, "R8 slave transmit", got, t);
                check(rx_data == r && rxf_req, "R8 slave receive", rx_data, r);
                clr(3'b010);
            end
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule